// File: doc/BRIEF.md
# Windowed Load/Store Workload Predictor

This block watches the memory-instruction rate coming out of an instruction decoder and decides how deep a variable-depth pipeline should run. Each clock cycle the decoder reports how many loads and stores it decoded in that cycle. The predictor keeps those per-cycle counts for the last 32 cycles and keeps a running total of them. It compares that total against a threshold that software or a power manager supplies.

When the recent memory traffic is above the threshold, the pipeline is bound by memory and gains little from its short stages. The predictor then raises a registered merge request, and the pipeline joins adjacent stages to save energy. In every other case the request is low and the pipeline keeps all stages separate for speed.

Alongside the request the block drives a stage-enable mask that the pipeline registers use directly. In the merged setting every second pipeline register is bypassed. Both outputs are registered, and they move only when the outcome of the comparison moves.

Top module: `lsw_depth_predictor`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `low_energy` is 0 and `stage_en` is 7'b1111111. A reset also empties the window, so counts seen before the reset never affect the total afterwards.
- R2: A count sampled at a rising edge stays in the window for exactly 32 edges: it is added at that edge and taken out again at the 32nd edge after it.
- R3: The merge decision uses a strict greater-than. A total equal to `unify_thr` gives `low_energy` = 0, and a total one above it gives `low_energy` = 1.
- R4: With `unify_thr` = 14 and a window total of 16 (eight cycles of count 2), `low_energy` becomes 1.
- R5: `stage_en` is 7'b1010101 (bits 0, 2, 4 and 6 set) whenever `low_energy` is 1, and 7'b1111111 whenever `low_energy` is 0.
- R6: The total is kept by adding the arriving count and subtracting the departing count each cycle, and it always equals a full sum of the last 32 counts.
- R7: Every count value from 0 to 3 is accepted. The largest total, 96 (32 cycles of 3), is held without wrapping: it merges against a threshold of 95 and does not merge against 96.
- R8: During the first 32 cycles after reset, window slots that have not been written count as zero.
- R9: `low_energy` after rising edge n+1 equals (window total after edge n) > (`unify_thr` sampled at edge n+1). The output holds its value whenever that comparison is unchanged.
- R10: A change of `unify_thr` alone has its effect one edge later and does not alter the stored counts. Moving the threshold back restores the earlier decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ls_count | input | 2 | Loads plus stores decoded in this cycle (0..3) |
| unify_thr | input | 7 | Merge threshold compared against the 32-cycle total |
| low_energy | output | 1 | Registered merge request: 1 = merge stages, 0 = full depth |
| stage_en | output | 7 | Registered per-stage register enable mask |

## Verification
A wrong running total never shows at the ports on its own. It appears only when the bad total falls on the other side of the threshold, so the bench sweeps the threshold around the exact total, including the values equal to it and one below it. A departing count that is dropped or taken from the wrong slot shows up exactly 32 edges after the count arrived. The window is also filled with high counts just before a reset, so that any leftover memory contents change the decision during the 32 cycles after reset. A fault in the compare or mask registers shows at the ports one edge after the total crosses the threshold.

// File: rtl/lsw_pkg.sv
package lsw_pkg;

  typedef enum logic {
    DEPTH_FULL   = 1'b0,
    DEPTH_MERGED = 1'b1
  } depth_mode_e;

  // Width that holds win_len * (2**cnt_w - 1) without wrap.
  function automatic int sum_width(input int win_len, input int cnt_w);
    return $clog2(win_len * ((1 << cnt_w) - 1) + 1);
  endfunction

  function automatic int ptr_width(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/lsw_window_buf.sv
// Circular history of per-cycle counts. One write per cycle. The entry leaving
// the window is fetched one cycle ahead through a registered read port, so the
// storage maps onto a simple dual-port RAM.
module lsw_window_buf #(
  parameter int DATA_W = 2,
  parameter int DEPTH  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] evict_data
);
  import lsw_pkg::*;

  localparam int PTR_W = ptr_width(DEPTH);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr;
  logic [PTR_W-1:0]  rd_addr;
  logic [DATA_W-1:0] rd_q;
  logic              full_q;

  // Slot that the next write overwrites, i.e. the oldest entry one cycle later.
  assign rd_addr = (wptr == LAST) ? '0 : wptr + 1'b1;

  always_ff @(posedge clk) begin
    mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    rd_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr   <= '0;
      full_q <= 1'b0;
    end else begin
      wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (wptr == LAST) full_q <= 1'b1;
    end
  end

  // Slots never written since reset count as zero.
  assign evict_data = full_q ? rd_q : '0;

endmodule

// File: rtl/lsw_running_sum.sv
// Incremental window total: add the arriving count, drop the departing one.
module lsw_running_sum #(
  parameter int CNT_W = 2,
  parameter int SUM_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] add_val,
  input  logic [CNT_W-1:0] sub_val,
  output logic [SUM_W-1:0] sum_q
);
  logic [SUM_W-1:0] add_ext;
  logic [SUM_W-1:0] sub_ext;

  assign add_ext = {{(SUM_W-CNT_W){1'b0}}, add_val};
  assign sub_ext = {{(SUM_W-CNT_W){1'b0}}, sub_val};

  always_ff @(posedge clk) begin
    if (rst) sum_q <= '0;
    else     sum_q <= sum_q + add_ext - sub_ext;
  end

endmodule

// File: rtl/lsw_mode_reg.sv
// Registered threshold compare and stage-enable mask.
module lsw_mode_reg #(
  parameter int SUM_W  = 7,
  parameter int STAGES = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SUM_W-1:0]  sum,
  input  logic [SUM_W-1:0]  thr,
  output logic              merge_q,
  output logic [STAGES-1:0] mask_q
);
  import lsw_pkg::*;

  depth_mode_e next_mode;

  assign next_mode = (sum > thr) ? DEPTH_MERGED : DEPTH_FULL;

  always_ff @(posedge clk) begin
    if (rst) merge_q <= 1'b0;
    else     merge_q <= (next_mode == DEPTH_MERGED);
  end

  // Even-numbered stage registers always clock; odd ones drop out when merged.
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i % 2 == 0) begin : g_keep
      always_ff @(posedge clk) begin
        mask_q[i] <= 1'b1;
      end
    end else begin : g_merge
      always_ff @(posedge clk) begin
        if (rst) mask_q[i] <= 1'b1;
        else     mask_q[i] <= (next_mode == DEPTH_FULL);
      end
    end
  end

endmodule

// File: rtl/lsw_depth_predictor.sv
module lsw_depth_predictor #(
  parameter  int CNT_W   = 2,
  parameter  int WIN_LEN = 32,
  parameter  int STAGES  = 7,
  localparam int SUM_W   = lsw_pkg::sum_width(WIN_LEN, CNT_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  ls_count,
  input  logic [SUM_W-1:0]  unify_thr,
  output logic              low_energy,
  output logic [STAGES-1:0] stage_en
);

  logic [CNT_W-1:0] leaving;
  logic [SUM_W-1:0] win_sum;

  lsw_window_buf #(
    .DATA_W (CNT_W),
    .DEPTH  (WIN_LEN)
  ) u_window (
    .clk        (clk),
    .rst        (rst),
    .wr_data    (ls_count),
    .evict_data (leaving)
  );

  lsw_running_sum #(
    .CNT_W (CNT_W),
    .SUM_W (SUM_W)
  ) u_sum (
    .clk     (clk),
    .rst     (rst),
    .add_val (ls_count),
    .sub_val (leaving),
    .sum_q   (win_sum)
  );

  lsw_mode_reg #(
    .SUM_W  (SUM_W),
    .STAGES (STAGES)
  ) u_mode (
    .clk     (clk),
    .rst     (rst),
    .sum     (win_sum),
    .thr     (unify_thr),
    .merge_q (low_energy),
    .mask_q  (stage_en)
  );

endmodule

// File: rtl/lsw_depth_predictor_chk.sv
module lsw_depth_predictor_chk #(
  parameter  int CNT_W   = 2,
  parameter  int WIN_LEN = 32,
  parameter  int STAGES  = 7,
  localparam int SUM_W   = lsw_pkg::sum_width(WIN_LEN, CNT_W)
) (
  input logic              clk,
  input logic              rst,
  input logic [CNT_W-1:0]  ls_count,
  input logic [SUM_W-1:0]  unify_thr,
  input logic [SUM_W-1:0]  win_sum,
  input logic              low_energy,
  input logic [STAGES-1:0] stage_en
);
  localparam int MAX_SUM = WIN_LEN * ((1 << CNT_W) - 1);

  logic [STAGES-1:0] merged_mask;
  logic [CNT_W-1:0]  hist [WIN_LEN];
  logic [SUM_W-1:0]  shadow_sum;
  logic              past_ok;

  always_comb begin
    for (int i = 0; i < STAGES; i++) merged_mask[i] = (i % 2 == 0);
  end

  // Shift-register copy of the window, summed in full each cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WIN_LEN; i++) hist[i] <= '0;
      past_ok <= 1'b0;
    end else begin
      hist[0] <= ls_count;
      for (int i = 1; i < WIN_LEN; i++) hist[i] <= hist[i-1];
      past_ok <= 1'b1;
    end
  end

  always_comb begin
    shadow_sum = '0;
    for (int i = 0; i < WIN_LEN; i++)
      shadow_sum = shadow_sum + {{(SUM_W-CNT_W){1'b0}}, hist[i]};
  end

  // R1: the first cycle out of reset shows the full-depth outputs
  p_reset_out_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!low_energy && stage_en == {STAGES{1'b1}}));

  // R5: mask encoding tracks the mode
  p_mask_code_r5: assert property (@(posedge clk) disable iff (rst)
    stage_en == (low_energy ? merged_mask : {STAGES{1'b1}}));

  // R6: incremental total matches a full recompute
  p_sum_recompute_r6: assert property (@(posedge clk) disable iff (rst)
    win_sum == shadow_sum);

  // R7: total never exceeds the largest reachable value
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    win_sum <= SUM_W'(MAX_SUM));

  // R9: mode reflects the previous total against the threshold
  p_mode_follows_r9: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (low_energy == ($past(win_sum) > $past(unify_thr))));

  // R9: no toggle while the comparison outcome is unchanged
  p_mode_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (past_ok && (($past(win_sum) > $past(unify_thr)) == $past(low_energy)))
      |-> $stable(low_energy));

endmodule

bind lsw_depth_predictor lsw_depth_predictor_chk #(
  .CNT_W   (CNT_W),
  .WIN_LEN (WIN_LEN),
  .STAGES  (STAGES)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ls_count   (ls_count),
  .unify_thr  (unify_thr),
  .win_sum    (win_sum),
  .low_energy (low_energy),
  .stage_en   (stage_en)
);

// File: tb/lsw_depth_predictor_test.sv
`timescale 1ns/1ps
module lsw_depth_predictor_test;

  localparam int WIN = 32;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] ls_count = '0;
  logic [6:0] unify_thr = '0;
  logic       low_energy;
  logic [6:0] stage_en;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  typedef struct {
    int    due;
    bit    le;
    string tag;
  } item_t;

  item_t sb[$];
  int    hist[$];

  lsw_depth_predictor uut (
    .clk        (clk),
    .rst        (rst),
    .ls_count   (ls_count),
    .unify_thr  (unify_thr),
    .low_energy (low_energy),
    .stage_en   (stage_en)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  function automatic int model_sum();
    int s = 0;
    foreach (hist[i]) s += hist[i];
    return s;
  endfunction

  // Driver: new count and threshold before the next edge; the mode after that
  // edge is the total so far compared with the new threshold.
  task automatic step(input int c, input int t, input string tag);
    item_t it;
    @(negedge clk);
    ls_count  = 2'(c);
    unify_thr = 7'(t);
    it.due = cyc + 1;
    it.le  = (model_sum() > t);
    it.tag = tag;
    sb.push_back(it);
    hist.push_back(c);
    if (hist.size() > WIN) void'(hist.pop_front());
  endtask

  task automatic reset_dut();
    @(negedge clk);
    rst = 1'b1;
    ls_count = '0;
    repeat (3) @(negedge clk);
    @(posedge clk); #2;
    chk(low_energy == 1'b0, "R1 mode in reset", int'(low_energy), 0);
    chk(stage_en == 7'b1111111, "R1 mask in reset", int'(stage_en), 7'h7F);
    hist.delete();
    @(negedge clk);
    rst = 1'b0;
    // the release edge samples this cycle's count of zero
    step_after_release();
  endtask

  task automatic step_after_release();
    item_t it;
    ls_count = '0;
    it.due = cyc + 1;
    it.le  = 1'b0;
    it.tag = "R1 first cycle after reset";
    sb.push_back(it);
    hist.push_back(0);
  endtask

  // Monitor: compares due items after each edge.
  always begin : monitor
    item_t it;
    @(posedge clk); #2;
    while (sb.size() > 0 && sb[0].due == cyc) begin
      it = sb.pop_front();
      chk(low_energy == it.le, {it.tag, " (R9 mode)"}, int'(low_energy), int'(it.le));
      chk(stage_en == (it.le ? 7'b1010101 : 7'b1111111), {it.tag, " (R5 mask)"},
          int'(stage_en), it.le ? 7'h55 : 7'h7F);
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stimulus
    logic [15:0] lf = 16'hACE1;
    reset_dut();

    // R8: fill from empty with ones, threshold 20
    for (int i = 0; i < WIN; i++) step(1, 20, "R8 fill from empty");
    // R2: ones leave exactly 32 edges after entering
    for (int i = 0; i < WIN + 4; i++) step(0, 20, "R2 drain");

    // R4: 8 cycles of 2 against 14
    for (int i = 0; i < 8; i++) step(2, 14, "R4 worked case");
    for (int i = 0; i < 4; i++) step(0, 14, "R4 hold");
    // R3: total 16 equal to threshold, then one above
    for (int i = 0; i < 3; i++) step(0, 16, "R3 equal");
    for (int i = 0; i < 3; i++) step(0, 15, "R3 one below thr");
    // R10: threshold back, counts unchanged
    for (int i = 0; i < 3; i++) step(0, 16, "R10 thr restored");
    for (int i = 0; i < 3; i++) step(0, 14, "R10 thr lowered");
    for (int i = 0; i < WIN; i++) step(0, 14, "R2 burst leaves");

    // R7: saturate with threes
    for (int i = 0; i < WIN + 8; i++) step(3, 95, "R7 fill max");
    for (int i = 0; i < 4; i++) step(3, 96, "R7 equal max");
    for (int i = 0; i < 4; i++) step(3, 95, "R7 below max");

    // R6: pseudo-random counts with moving threshold
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(int'(lf[1:0]), 30 + (i / 20) * 2, "R6 random window");
    end

    // R1/R8: reset with a loaded window; old contents must not leak
    for (int i = 0; i < 10; i++) step(3, 5, "R1 preload");
    reset_dut();
    for (int i = 0; i < WIN + 6; i++) step(0, 0, "R8 no leak after reset");
    for (int i = 0; i < WIN + 6; i++) step(1, 31, "R8 refill");

    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R9 scoreboard drained", sb.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule